// File: doc/BRIEF.md
# Wait-State Memory Bus Target

This block is a synchronous memory slave for a simple 32-bit processor bus. The bus has separate address, write-data and read-data paths. The master marks a transfer with three strobes: `rd`, `wr` and `fetch`. The target answers with a single `ready` line. It holds a small word-addressed RAM and serves instruction fetches, data loads and stores from it. It stretches every transfer by a fixed, parameterised number of wait cycles.

A transfer takes three kinds of cycle:

1. An address cycle: the master sets up the address while all strobes are low.
2. A strobe cycle: the master raises its strobes. A fetch raises `rd` and `fetch` together, a load raises `rd` alone, and a store raises `wr` and drives `wdata`.
3. One or more data cycles: the target holds `ready` low for `WAITS` data cycles, then raises it for exactly one cycle. In that cycle a store is committed and a read is taken by the master.

The master then drops its strobes in the next address cycle. Completed fetches are counted separately from data loads.

Top module: `mbt_target`

## Requirements
- R1: While reset is asserted, `ready` is 0 and `fetch_count` is 0, and reset clears the wait counter.
- R2: For each transfer, `ready` stays low for exactly `WAITS` data cycles after the strobe cycle, then is high in the next data cycle. With `WAITS` between 0 and 7, the first high sample falls in data cycle `WAITS`+1. `ready` is high for one cycle only.
- R3: `ready` is never high in the address cycle, in the strobe cycle, or while no strobe is asserted.
- R4: During every data cycle of a read, `rdata` equals the memory word at the current address. The value holds steady through all wait cycles.
- R5: Whenever `rd` is low, `rdata` is zero.
- R6: A store writes `wdata` into the word at the current address on the data cycle in which `ready` is high. Later reads of that word return the stored value.
- R7: When `rd` and `wr` are high together, the target never raises `ready` and leaves the memory unchanged.
- R8: `fetch_count` rises by exactly 1 for each completed transfer with `fetch` and `rd` both high. Loads, stores and unfinished transfers leave it unchanged.
- R9: The word index is the low log2(`DEPTH`) address bits, `addr[7:0]` by default. Higher address bits are ignored, so address 0x105 selects the same word as 0x005.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address from the master |
| wdata | input | DATA_W | Store data from the master |
| rdata | output | DATA_W | Read data, zero while `rd` is low |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| fetch | input | 1 | Marks a read as an instruction fetch |
| ready | output | 1 | Transfer completes in this data cycle |
| fetch_count | output | FCNT_W | Number of completed instruction fetches |

## Verification
The bench counts data cycles up to the first high `ready` sample on every transfer. An off-by-one in the wait counter therefore shows up as a transfer one cycle short or one cycle long. It checks `rdata` in every wait cycle of a read, so a design that only presents data when `ready` rises is caught. It holds `rd` and `wr` high together for many cycles and then reads the word back. A target that completes the clashing transfer raises `ready`, and one that writes anyway returns the new value. It mixes fetches, loads and stores and compares `fetch_count` against its own tally, and it reads through an aliased address, so a counter that counts every read or a decoder that uses too many address bits gives the wrong number or the wrong word.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_DATA  = 2'd1,
      SQ_DRAIN = 2'd2
   } sq_state_t;
endpackage

// File: rtl/mbt_seq.sv
module mbt_seq
   import mbt_pkg::*;
#(
   parameter int WAITS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd,
   input  logic wr,
   output logic ready
);
   localparam int WCNT_W = (WAITS < 2) ? 1 : $clog2(WAITS + 1);

   sq_state_t state_q, state_d;
   logic      strobe, clash, cnt_zero, load_cnt, dec_cnt;

   assign strobe = rd | wr;
   assign clash  = rd & wr;

   always_comb begin
      state_d = state_q;
      case (state_q)
         SQ_IDLE: begin
            if (strobe) state_d = clash ? SQ_DRAIN : SQ_DATA;
         end
         SQ_DATA: begin
            if (!strobe)      state_d = SQ_IDLE;
            else if (clash)   state_d = SQ_DRAIN;
            else if (cnt_zero) state_d = SQ_DRAIN;
         end
         SQ_DRAIN: begin
            if (!strobe) state_d = SQ_IDLE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   assign load_cnt = (state_q == SQ_IDLE) & strobe & ~clash;
   assign dec_cnt  = (state_q == SQ_DATA) & strobe & ~clash & ~cnt_zero;

   generate
      if (WAITS == 0) begin : g_nowait
         assign cnt_zero = 1'b1;
      end else begin : g_wait
         logic [WCNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cnt_q <= '0;
            else if (load_cnt) cnt_q <= WCNT_W'(WAITS);
            else if (dec_cnt)  cnt_q <= cnt_q - 1'b1;
         end
         assign cnt_zero = (cnt_q == '0);
      end
   endgenerate

   assign ready = (state_q == SQ_DATA) & strobe & ~clash & cnt_zero;
endmodule

// File: rtl/mbt_ram.sv
module mbt_ram #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[idx] <= wdata;
   end

   assign rdata = words[idx];
endmodule

// File: rtl/mbt_fcount.sv
module mbt_fcount #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/mbt_target.sv
module mbt_target #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   parameter int WAITS  = 2,
   parameter int FCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              rd,
   input  logic              wr,
   input  logic              fetch,
   output logic              ready,
   output logic [FCNT_W-1:0] fetch_count
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (WAITS < 0 || WAITS > 7) begin : g_bad_waits
         $error("WAITS must lie between 0 and 7");
      end
      if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (IDX_W < 1 || IDX_W > ADDR_W) begin : g_bad_idx
         $error("DEPTH does not fit the address width");
      end
   endgenerate

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] ram_rdata;
   logic              commit_wr, fetch_done;

   assign idx = addr[IDX_W-1:0];

   generate
      if (ADDR_W > IDX_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^addr[ADDR_W-1:IDX_W];
      end
   endgenerate

   mbt_seq #(.WAITS(WAITS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .rd    (rd),
      .wr    (wr),
      .ready (ready)
   );

   assign commit_wr  = ready & wr;
   assign fetch_done = ready & rd & fetch;

   mbt_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
      .clk   (clk),
      .we    (commit_wr),
      .idx   (idx),
      .wdata (wdata),
      .rdata (ram_rdata)
   );

   mbt_fcount #(.CNT_W(FCNT_W)) u_fcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (fetch_done),
      .count (fetch_count)
   );

   assign rdata = rd ? ram_rdata : '0;
endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk #(
   parameter int DATA_W = 32,
   parameter int FCNT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd,
   input logic              wr,
   input logic              fetch,
   input logic              ready,
   input logic [DATA_W-1:0] rdata,
   input logic [FCNT_W-1:0] fetch_count
);
   // R1
   always @(negedge clk) begin
      if (!rst_n) begin
         reset_idle_chk: assert (!ready && fetch_count == '0);
      end
   end

   // R3
   ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (rd || wr));

   // R7
   clash_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && wr) |-> !ready);

   // R5
   rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |-> (rdata == '0));

   // R2
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   // R8
   fcnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rd && fetch) |=> (fetch_count == $past(fetch_count) + 1'b1));

   // R8
   fcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && rd && fetch) |=> $stable(fetch_count));
endmodule

bind mbt_target mbt_target_chk #(.DATA_W(DATA_W), .FCNT_W(FCNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd          (rd),
   .wr          (wr),
   .fetch       (fetch),
   .ready       (ready),
   .rdata       (rdata),
   .fetch_count (fetch_count)
);

// File: tb/sim_mbt_target.sv
`timescale 1ns/1ps
module sim_mbt_target;
   localparam int WAITS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] addr = '0, wdata = '0;
   logic [31:0] rdata;
   logic        rd = 1'b0, wr = 1'b0, fetch = 1'b0;
   logic        ready;
   logic [15:0] fetch_count;

   int n_chk = 0, n_fail = 0, n_fetch = 0;
   bit finished = 1'b0;
   logic [31:0] model [256];
   logic [31:0] exp_q [$];

   always #2.5 clk = ~clk;

   mbt_target #(.WAITS(WAITS)) u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rdata(rdata),
      .rd(rd), .wr(wr), .fetch(fetch), .ready(ready), .fetch_count(fetch_count)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Scoreboard monitor: pops an expected read word whenever a read completes.
   always begin
      @(negedge clk);
      #1;
      if (rst_n && ready && rd) begin
         if (exp_q.size() == 0) check(1'b0, "R4", rdata, 32'hx);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(rdata == e, "R4", rdata, e);
         end
      end
   end

   // kind: 0 fetch, 1 load, 2 store
   task automatic xfer(input int kind, input logic [31:0] a, input logic [31:0] d);
      int n = 0;
      logic [31:0] e;
      @(negedge clk);
      rd = 0; wr = 0; fetch = 0; addr = a;
      #1 check(ready == 1'b0, "R3", {31'd0, ready}, 32'd0);
      e = model[a[7:0]];
      if (kind < 2) exp_q.push_back(e);
      @(negedge clk);
      rd = (kind < 2); fetch = (kind == 0); wr = (kind == 2); wdata = d;
      #1 check(ready == 1'b0, "R3", {31'd0, ready}, 32'd0);
      forever begin
         @(negedge clk);
         #1;
         n++;
         if (kind < 2 && rdata !== e) check(1'b0, "R4", rdata, e);
         if (ready || n > 20) break;
      end
      check(n == WAITS + 1, "R2", n, WAITS + 1);
      if (kind == 2) model[a[7:0]] = d;
      if (kind == 0) n_fetch++;
   endtask

   task automatic go_idle();
      @(negedge clk);
      rd = 0; wr = 0; fetch = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(ready == 1'b0, "R1", {31'd0, ready}, 32'd0);
      check(fetch_count == 16'd0, "R1", {16'd0, fetch_count}, 32'd0);
      check(rdata == 32'd0, "R5", rdata, 32'd0);
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < 8; i++) xfer(2, i * 7, 32'hA500_0000 + i * 32'h1111);
      xfer(2, 32'h0000_0005, 32'hDEAD_BEEF);
      for (int i = 0; i < 8; i++) xfer(1, i * 7, 0);
      xfer(0, 32'h0000_0005, 0);
      xfer(0, 32'h0000_0000, 0);
      // R9: high address bits ignored, 0x105 is word 5
      xfer(1, 32'h0000_0105, 0);
      xfer(0, 32'hFFFF_FF07, 0);
      go_idle();
      #1 check(fetch_count == 16'(n_fetch), "R8", {16'd0, fetch_count}, n_fetch);

      // R6: overwrite through aliased address and read back
      xfer(2, 32'h0000_0207, 32'h1234_5678);
      xfer(1, 32'h0000_0007, 0);
      go_idle();
      #1 check(model[7] == 32'h1234_5678, "R6", model[7], 32'h1234_5678);

      // R5: address changes with rd low
      addr = 32'h0000_0005;
      #1 check(rdata == 32'd0, "R5", rdata, 32'd0);

      // R7: rd and wr together
      @(negedge clk);
      addr = 32'h0000_0005; rd = 1; wr = 1; wdata = 32'h0BAD_0BAD;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         #1;
         if (ready) check(1'b0, "R7", {31'd0, ready}, 32'd0);
      end
      check(ready == 1'b0, "R7", {31'd0, ready}, 32'd0);
      xfer(1, 32'h0000_0005, 0);
      go_idle();
      #1 check(fetch_count == 16'(n_fetch), "R8", {16'd0, fetch_count}, n_fetch);
      check(exp_q.size() == 0, "R4", exp_q.size(), 0);
      check(ready == 1'b0, "R3", {31'd0, ready}, 32'd0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         check(1'b0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule